// File: doc/BRIEF.md
# Branch Next-Address Unit

This unit resolves where instruction flow continues after a branch. Each request carries the address of the branch, a sign-extended displacement, an absolute-address flag, the contents of the link and count registers, a selector choosing where the target comes from, the result of the condition test, a count-decrement enable with its test polarity, an unconditional flag and the current 64-bit mode bit. The unit returns the next address, a taken flag and the count register value to write back.

Requests and results travel as valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its result appears on `rsp_*` one cycle later. A result stays on the outputs, unchanged, until a rising edge sees `rsp_ready` high. `req_ready` is high whenever the result slot is empty or is being emptied in the same cycle, so back-to-back requests flow at one per cycle with no bubble. Decode, the condition register itself and fetch stay outside the unit.

In 32-bit mode the unit keeps only the low half of every next address, whether taken or fall-through, and evaluates the count test on the low 32 bits only.

Top module: `branch_next_addr`

## Requirements
- R1: With target select 2'b00 and the absolute flag clear, a taken branch continues at `req_pc + req_disp` (modulo 2^64).
- R2: With target select 2'b00 and the absolute flag set, a taken branch continues at `req_disp` alone, whatever the PC.
- R3: Target select 2'b01 takes the link register and 2'b10 or 2'b11 takes the count register as it was on entry (before any decrement); in both cases bits [1:0] of the target are forced to zero.
- R4: A branch that is not taken continues at `req_pc + 4`.
- R5: When `req_mode64` is 0, bits [63:32] of the next address are zero for taken and not-taken branches alike; when it is 1, all 64 bits are kept.
- R6: A conditional branch (`req_uncond` = 0) is taken only when `req_cond_ok` is 1 and the count test passes; the count test passes trivially when decrement is off.
- R7: With `req_ctr_dec` = 1 the returned count is the entry count minus one (wrapping from zero to all ones), written back whether or not the branch is taken; with `req_ctr_dec` = 0 it is the entry count unchanged.
- R8: The count test looks at the decremented value: `req_ctr_zero` = 1 passes when it is zero, `req_ctr_zero` = 0 passes when it is nonzero; in 32-bit mode only its low 32 bits are examined.
- R9: With `req_uncond` = 1 the branch is taken regardless of the condition and the count test.
- R10: A request accepted at a clock edge yields `rsp_valid` = 1 with its result after that edge, and while `rsp_valid` = 1 and `rsp_ready` = 0 all `rsp_*` outputs hold their values.
- R11: After reset `rsp_valid` is 0; `req_ready` equals `!rsp_valid || rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_pc | input | 64 | Address of the branch |
| req_disp | input | 64 | Sign-extended displacement |
| req_abs | input | 1 | Displacement is an absolute address |
| req_link | input | 64 | Link register contents |
| req_count | input | 64 | Count register contents on entry |
| req_tgt_sel | input | 2 | 00 displacement, 01 link, 1x count |
| req_cond_ok | input | 1 | Condition test passed |
| req_uncond | input | 1 | Branch is unconditional |
| req_ctr_dec | input | 1 | Decrement and test the count register |
| req_ctr_zero | input | 1 | Count test passes on zero (1) or nonzero (0) |
| req_mode64 | input | 1 | 64-bit mode (1) or 32-bit mode (0) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_next_addr | output | 64 | Next instruction address |
| rsp_taken | output | 1 | Branch taken |
| rsp_count | output | 64 | Count register value to write back |

## Verification
The hardest situation to reach is a 32-bit-mode count test whose decremented value is zero in its low half but nonzero above it, because random 64-bit counts almost never land there and the two modes must then disagree. Directed requests load counts such as 0x1_0000_0001 and 0x1 in both modes and both test polarities, and also wrap a zero count and a PC just below a 4 GiB boundary. Random requests bias the count toward small values so the decrement lands on zero often, and they mix random stalls on `rsp_ready` with back-to-back bursts.

// File: rtl/bna_pkg.sv
package bna_pkg;
  typedef enum logic [1:0] {
    SRC_DISP      = 2'b00,
    SRC_LINK      = 2'b01,
    SRC_COUNT     = 2'b10,
    SRC_COUNT_ALT = 2'b11
  } tgt_src_e;
endpackage

// File: rtl/bna_target.sv
module bna_target #(
  parameter int AW = 64,
  parameter int AB = 2
) (
  input  logic [AW-1:0]        pc,
  input  logic [AW-1:0]        disp,
  input  logic                 abs_en,
  input  logic [AW-1:0]        link,
  input  logic [AW-1:0]        count,
  input  bna_pkg::tgt_src_e    sel,
  output logic [AW-1:0]        target
);
  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << AB) - AW'(1));

  logic [AW-1:0] disp_tgt;

  always_comb begin
    disp_tgt = abs_en ? disp : pc + disp;
    unique case (sel)
      bna_pkg::SRC_DISP:  target = disp_tgt;
      bna_pkg::SRC_LINK:  target = link & ALIGN_MASK;
      default:            target = count & ALIGN_MASK;
    endcase
  end

  // register-sourced targets come out aligned
  always_comb begin
    if (sel != bna_pkg::SRC_DISP)
      AST_REG_ALIGNED: assert (target[AB-1:0] == '0); // R3
  end
endmodule

// File: rtl/bna_count.sv
module bna_count #(
  parameter int AW = 64,
  parameter int LW = 32
) (
  input  logic [AW-1:0] count_in,
  input  logic          dec_en,
  input  logic          test_zero,
  input  logic          mode64,
  output logic [AW-1:0] count_out,
  output logic          ctr_ok
);
  logic [AW-1:0] tested;
  logic [AW-1:0] low_mask;

  generate
    if (LW < AW) begin : g_narrow
      assign low_mask = {{(AW-LW){mode64}}, {LW{1'b1}}};
    end else begin : g_full
      assign low_mask = '1;
    end
  endgenerate

  always_comb begin
    count_out = dec_en ? count_in - AW'(1) : count_in;
    tested    = count_out & low_mask;
    if (!dec_en)
      ctr_ok = 1'b1;
    else if (test_zero)
      ctr_ok = (tested == '0);
    else
      ctr_ok = (tested != '0);
  end
endmodule

// File: rtl/bna_resolve.sv
module bna_resolve #(
  parameter int AW   = 64,
  parameter int LW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          uncond,
  input  logic          cond_ok,
  input  logic          ctr_ok,
  input  logic          mode64,
  output logic          taken,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] mode_mask;
  logic [AW-1:0] raw_next;

  generate
    if (LW < AW) begin : g_narrow
      assign mode_mask = {{(AW-LW){mode64}}, {LW{1'b1}}};
    end else begin : g_full
      assign mode_mask = '1;
    end
  endgenerate

  always_comb begin
    taken     = uncond | (cond_ok & ctr_ok);
    raw_next  = taken ? target : pc + AW'(STEP);
    next_addr = raw_next & mode_mask;
  end
endmodule

// File: rtl/branch_next_addr.sv
module branch_next_addr #(
  parameter int ADDR_W     = 64,
  parameter int NARROW_W   = 32,
  parameter int INSN_BYTES = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_disp,
  input  logic              req_abs,
  input  logic [ADDR_W-1:0] req_link,
  input  logic [ADDR_W-1:0] req_count,
  input  logic [1:0]        req_tgt_sel,
  input  logic              req_cond_ok,
  input  logic              req_uncond,
  input  logic              req_ctr_dec,
  input  logic              req_ctr_zero,
  input  logic              req_mode64,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_next_addr,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_count
);
  bna_pkg::tgt_src_e sel;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] count_nxt;
  logic [ADDR_W-1:0] next_addr;
  logic              ctr_ok;
  logic              taken;
  logic              accept;

  assign sel       = bna_pkg::tgt_src_e'(req_tgt_sel);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  bna_target #(.AW(ADDR_W), .AB(ALIGN_BITS)) u_target (
    .pc     (req_pc),
    .disp   (req_disp),
    .abs_en (req_abs),
    .link   (req_link),
    .count  (req_count),
    .sel    (sel),
    .target (target)
  );

  bna_count #(.AW(ADDR_W), .LW(NARROW_W)) u_count (
    .count_in  (req_count),
    .dec_en    (req_ctr_dec),
    .test_zero (req_ctr_zero),
    .mode64    (req_mode64),
    .count_out (count_nxt),
    .ctr_ok    (ctr_ok)
  );

  bna_resolve #(.AW(ADDR_W), .LW(NARROW_W), .STEP(INSN_BYTES)) u_resolve (
    .pc        (req_pc),
    .target    (target),
    .uncond    (req_uncond),
    .cond_ok   (req_cond_ok),
    .ctr_ok    (ctr_ok),
    .mode64    (req_mode64),
    .taken     (taken),
    .next_addr (next_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_next_addr <= '0;
      rsp_taken     <= 1'b0;
      rsp_count     <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_next_addr <= next_addr;
      rsp_taken     <= taken;
      rsp_count     <= count_nxt;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R11
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R10
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_next_addr) && $stable(rsp_taken) && $stable(rsp_count)); // R10
  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_uncond |=> rsp_taken); // R9
  AST_COND_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_uncond && !req_cond_ok |=> !rsp_taken); // R6
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_uncond && !req_cond_ok && req_mode64 |=> rsp_next_addr == $past(req_pc) + ADDR_W'(INSN_BYTES)); // R4
  AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_mode64 |=> (rsp_next_addr >> NARROW_W) == '0); // R5
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_ctr_dec |=> rsp_count == $past(req_count) - ADDR_W'(1)); // R7
endmodule

// File: tb/branch_next_addr_bench.sv
module branch_next_addr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_pc = '0, req_disp = '0, req_link = '0, req_count = '0;
  logic        req_abs = 1'b0;
  logic [1:0]  req_tgt_sel = '0;
  logic        req_cond_ok = 1'b0, req_uncond = 1'b0, req_ctr_dec = 1'b0;
  logic        req_ctr_zero = 1'b0, req_mode64 = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_next_addr;
  logic        rsp_taken;
  logic [63:0] rsp_count;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  branch_next_addr u_branch_next_addr (.*);

  function automatic void model(
    input  logic [63:0] pc, disp, link, cnt,
    input  logic abs_f, input logic [1:0] sel,
    input  logic cok, unc, den, tz, m64,
    output logic [63:0] nxt, output logic tk, output logic [63:0] cnt_o);
    logic [63:0] tgt, tv;
    logic pass;
    cnt_o = den ? cnt - 64'd1 : cnt;
    tv    = m64 ? cnt_o : {32'h0, cnt_o[31:0]};
    pass  = !den || (tz ? (tv == 0) : (tv != 0));
    tk    = unc || (cok && pass);
    if (sel == 2'b00)      tgt = abs_f ? disp : pc + disp;
    else if (sel == 2'b01) tgt = link & ~64'h3;
    else                   tgt = cnt & ~64'h3;
    nxt = tk ? tgt : pc + 64'd4;
    if (!m64) nxt[63:32] = 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] e_nxt, e_cnt;
  logic        e_tk;

  task automatic drive(input logic [63:0] pc, disp, link, cnt, input logic abs_f,
                       input logic [1:0] sel, input logic cok, unc, den, tz, m64);
    req_pc = pc; req_disp = disp; req_link = link; req_count = cnt; req_abs = abs_f;
    req_tgt_sel = sel; req_cond_ok = cok; req_uncond = unc; req_ctr_dec = den;
    req_ctr_zero = tz; req_mode64 = m64; req_valid = 1'b1;
    model(pc, disp, link, cnt, abs_f, sel, cok, unc, den, tz, m64, e_nxt, e_tk, e_cnt);
  endtask

  task automatic xact(input string tag, input logic [63:0] pc, disp, link, cnt,
                      input logic abs_f, input logic [1:0] sel,
                      input logic cok, unc, den, tz, m64, input int stall);
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(pc, disp, link, cnt, abs_f, sel, cok, unc, den, tz, m64);
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R10 valid ", tag}, 64'(rsp_valid), 64'd1);
    chk({tag, " addr"}, rsp_next_addr, e_nxt);
    chk({tag, " taken"}, 64'(rsp_taken), 64'(e_tk));
    chk({tag, " count"}, rsp_count, e_cnt);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R10 hold addr", rsp_next_addr, e_nxt);
      chk("R10 hold count", rsp_count, e_cnt);
      chk("R11 ready low while stalled", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // R1 relative, R9 unconditional with condition false
    xact("R1 R9", 64'h0000_1000_0000_0100, 64'hFFFF_FFFF_FFFF_FF00, 0, 5, 0, 2'b00, 0, 1, 0, 0, 1, 0);
    // R2 absolute
    xact("R2", 64'h1234_0000_0000_0000, 64'h0000_0000_0000_4000, 0, 5, 1, 2'b00, 1, 0, 0, 0, 1, 1);
    // R3 link, count, alternate code
    xact("R3 link", 64'h100, 0, 64'hDEAD_BEEF_0000_0007, 5, 0, 2'b01, 1, 0, 0, 0, 1, 0);
    xact("R3 count", 64'h100, 0, 0, 64'h0000_0000_0000_ABCF, 0, 2'b10, 0, 1, 0, 0, 1, 0);
    xact("R3 count alt pre-decrement", 64'h100, 0, 0, 64'h0000_0000_0000_2002, 0, 2'b11, 1, 0, 1, 0, 1, 2);
    // R4 not taken
    xact("R4", 64'h8000_0000_0000_0010, 64'h40, 0, 5, 0, 2'b00, 0, 0, 0, 0, 1, 0);
    // R5 32-bit wrap on fall-through and on taken
    xact("R5 fallthrough", 64'h0000_0001_FFFF_FFFC, 64'h40, 0, 5, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    xact("R5 taken", 64'hFFFF_0000_FFFF_FFF0, 64'h20, 0, 5, 0, 2'b00, 1, 0, 0, 0, 0, 0);
    // R6 R7 R8 count tests
    xact("R6 R8 nonzero fails", 64'h200, 64'h80, 0, 64'd1, 0, 2'b00, 1, 0, 1, 0, 1, 0);
    xact("R8 zero passes", 64'h200, 64'h80, 0, 64'd1, 0, 2'b00, 1, 0, 1, 1, 1, 0);
    xact("R6 cond false count ok", 64'h200, 64'h80, 0, 64'd9, 0, 2'b00, 0, 0, 1, 0, 1, 0);
    xact("R8 narrow zero", 64'h200, 64'h80, 0, 64'h1_0000_0001, 0, 2'b00, 1, 0, 1, 1, 0, 0);
    xact("R8 wide nonzero", 64'h200, 64'h80, 0, 64'h1_0000_0001, 0, 2'b00, 1, 0, 1, 1, 1, 0);
    xact("R8 narrow nonzero fails", 64'h200, 64'h80, 0, 64'h1_0000_0001, 0, 2'b00, 1, 0, 1, 0, 0, 0);
    xact("R7 wrap", 64'h200, 64'h80, 0, 64'd0, 0, 2'b00, 1, 0, 1, 0, 1, 0);
    xact("R7 no decrement", 64'h200, 64'h80, 0, 64'd0, 0, 2'b00, 1, 0, 0, 1, 1, 0);
    xact("R9 ignores count", 64'h200, 64'h80, 0, 64'd1, 0, 2'b00, 0, 1, 1, 0, 1, 0);

    // back-to-back burst, R10 R11
    @(negedge clk);
    rsp_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        @(negedge clk);
        chk("R10 burst valid", 64'(rsp_valid), 64'd1);
        chk("R10 burst addr", rsp_next_addr, e_nxt);
        chk("R6 burst taken", 64'(rsp_taken), 64'(e_tk));
        chk("R7 burst count", rsp_count, e_cnt);
        chk("R11 burst ready", 64'(req_ready), 64'd1);
      end
      if (k < 5)
        drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 64'($urandom % 3),
              1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else
        req_valid = 1'b0;
    end
    @(negedge clk);
    rsp_ready = 1'b0;

    // random traffic
    for (int n = 0; n < 300; n++) begin
      logic [63:0] cnt;
      cnt = ($urandom % 2 == 0) ? 64'($urandom % 4) | (($urandom % 2 == 0) ? 64'h1_0000_0000 : 64'h0)
                                : {$urandom, $urandom};
      xact("R1 R6 R8 random", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, cnt,
           1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 4 == 0), 1'($urandom),
           1'($urandom), 1'($urandom), int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule